// File: doc/BRIEF.md
# Misaligned Memory Access Handler

This block sits between a load/store pipeline and a memory port that is one 32-bit word wide. Each request carries a byte address, a size code, a read/write flag, a signed flag for reads and the write data. The block checks the request for natural alignment. It then turns the request into word transactions with per-byte enables, or it refuses the request.

A policy input, sampled when a request is accepted, selects how a misaligned request is handled. Under the permissive policy, a request that spans two words is carried out as two word transactions. The first covers the lower-addressed word and the second covers the next one. Read bytes are put back together in little-endian order, and writes reach only the target bytes. Under the strict policy, any misaligned request produces a one-cycle trap pulse that carries the faulting address, and the memory port stays idle. Aligned requests take a single transaction under both policies.

The pipeline sees a simple protocol. `req_ready` shows the block can accept a request. `busy` covers the whole life of an access. `resp_done` pulses once when the final transaction has completed.

Top module: `misalign_access_unit`

## Requirements
- R1: Size codes are 0 = byte, 1 = halfword, 2 = word (code 3 behaves as word). An access is aligned when its byte address is a multiple of its size in bytes.
- R2: An aligned access issues exactly one memory transaction under either policy. With an immediate acknowledge, `resp_done` is high in the second cycle after the accepting edge.
- R3: Under the permissive policy, an access whose bytes cross a word boundary issues two transactions. The first goes to the word containing the start address and the second to the next word (address + 4). `busy` stays high and `mem_req` returns straight after the first acknowledge. With an immediate acknowledge, done comes in the third cycle.
- R4: A read returns its bytes little-endian (the byte at the start address lands in bits 7:0), taking the low-addressed bytes from the first word. Byte and halfword results are sign-extended when `req_signed` is 1 and zero-extended otherwise.
- R5: Bit i of `mem_be` marks byte lane i of the word. Byte k of `req_wdata` is driven on lane (offset + k) mod 4 of the transaction that covers it. Only the addressed bytes are enabled, so no other byte of memory changes.
- R6: Under the strict policy, a misaligned access produces `trap_pulse` for exactly one cycle, in the cycle after the accepting edge, with `trap_addr` equal to the request address. No memory request, no `resp_done` and no memory change result from it.
- R7: `resp_done` is a single-cycle pulse per completed access. `resp_rdata` holds the read result during it and is zero for writes.
- R8: `req_ready` is high only when no access is in progress, and is high after reset. Once raised, `mem_req`, `mem_addr` and `mem_be` hold steady until `mem_ack`.
- R9: Under the permissive policy, a misaligned access whose bytes lie within one word completes in one transaction with its lanes shifted.
- R10: Under the strict policy the block never issues a second transaction for one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | 1 = trap on misalignment, 0 = split and merge |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load result |
| trap_pulse | output | 1 | One-cycle misalignment trap |
| trap_addr | output | ADDR_W | Faulting address |
| busy | output | 1 | Access in progress |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | ADDR_W | Word-aligned transaction address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 32 | Read word, valid with mem_ack |

## Verification
The assertions assume that the memory side returns `mem_ack` only while `mem_req` is high, and that its read word is valid in the acknowledging cycle. They also assume the requester keeps its fields steady in the cycle it raises `req_valid`. The bench's memory model follows that rule. It decides each acknowledge at the falling edge from the request it sees, and it drives the read word in the same step. Requests are issued only after `req_ready` is seen high. The policy input changes only between accesses, once the block is idle. Acknowledge timing is either immediate, so that latency can be measured, or pseudo-random.

// File: rtl/mau_pkg.sv
package mau_pkg;

  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE,
    ST_TRAP
  } mau_state_e;

  // number of bytes touched by a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // natural alignment test on the low address bits
  function automatic logic is_aligned(input logic [OFF_W-1:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    is_aligned = 1'b1;
      2'd1:    is_aligned = (off[0] == 1'b0);
      default: is_aligned = (off == '0);
    endcase
  endfunction

  // lanes touched across two consecutive words, lower word in bits 3:0
  function automatic logic [2*WORD_BYTES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                        input logic [1:0] sz);
    logic [2*WORD_BYTES-1:0] base;
    case (sz)
      2'd0:    base = 8'b0000_0001;
      2'd1:    base = 8'b0000_0011;
      default: base = 8'b0000_1111;
    endcase
    lane_mask = base << off;
  endfunction

  // store data placed on the lanes of two consecutive words
  function automatic logic [2*DATA_W-1:0] place_wdata(input logic [DATA_W-1:0] wd,
                                                      input logic [OFF_W-1:0] off);
    logic [2*DATA_W-1:0] wide;
    wide = {{DATA_W{1'b0}}, wd};
    place_wdata = wide << {off, 3'b000};
  endfunction

  // pick the addressed bytes out of two words and extend them
  function automatic logic [DATA_W-1:0] gather_rdata(input logic [DATA_W-1:0] lo,
                                                     input logic [DATA_W-1:0] hi,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [1:0] sz,
                                                     input logic sgn);
    logic [2*DATA_W-1:0] wide;
    logic [DATA_W-1:0]   raw;
    wide = {hi, lo} >> {off, 3'b000};
    raw  = wide[DATA_W-1:0];
    case (sz)
      2'd0:    gather_rdata = sgn ? {{(DATA_W-8){raw[7]}}, raw[7:0]}
                                  : {{(DATA_W-8){1'b0}}, raw[7:0]};
      2'd1:    gather_rdata = sgn ? {{(DATA_W-16){raw[15]}}, raw[15:0]}
                                  : {{(DATA_W-16){1'b0}}, raw[15:0]};
      default: gather_rdata = raw;
    endcase
  endfunction

endpackage

// File: rtl/mau_lane_plan.sv
module mau_lane_plan
  import mau_pkg::*;
(
  input  logic [OFF_W-1:0]      off,
  input  logic [1:0]            size,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  aligned,
  output logic                  crosses,
  output logic [WORD_BYTES-1:0] be_first,
  output logic [WORD_BYTES-1:0] be_second,
  output logic [DATA_W-1:0]     wd_first,
  output logic [DATA_W-1:0]     wd_second
);

  logic [2*WORD_BYTES-1:0] lanes;
  logic [2*DATA_W-1:0]     placed;

  always_comb begin
    lanes     = lane_mask(off, size);
    placed    = place_wdata(wdata, off);
    aligned   = is_aligned(off, size);
    be_first  = lanes[WORD_BYTES-1:0];
    be_second = lanes[2*WORD_BYTES-1:WORD_BYTES];
    crosses   = |be_second;
    wd_first  = placed[DATA_W-1:0];
    wd_second = placed[2*DATA_W-1:DATA_W];
  end

endmodule

// File: rtl/mau_read_merge.sv
module mau_read_merge
  import mau_pkg::*;
(
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] result
);

  always_comb result = gather_rdata(lo_word, hi_word, off, size, sgn);

endmodule

// File: rtl/misalign_access_unit.sv
module misalign_access_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strict_mode,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic                  req_signed,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  resp_done,
  output logic [DATA_W-1:0]     resp_rdata,
  output logic                  trap_pulse,
  output logic [ADDR_W-1:0]     trap_addr,
  output logic                  busy,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [WORD_BYTES-1:0] mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

  mau_state_e st_q, st_d;

  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              sgn_q;
  logic              we_q;
  logic              strict_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] rdata_q;

  // named events for assertions
  logic acc_fire;
  logic aligned_in;
  logic txn_fire;
  logic first_fire;
  logic second_fire;
  logic in_second;

  logic                  aligned_q;
  logic                  split_q;
  logic [WORD_BYTES-1:0] be_first, be_second;
  logic [DATA_W-1:0]     wd_first, wd_second;
  logic [DATA_W-1:0]     merge_lo, merge_hi, merged;
  logic [ADDR_W-1:0]     base_addr;

  mau_lane_plan u_plan (
    .off       (addr_q[OFF_W-1:0]),
    .size      (size_q),
    .wdata     (wd_q),
    .aligned   (aligned_q),
    .crosses   (split_q),
    .be_first  (be_first),
    .be_second (be_second),
    .wd_first  (wd_first),
    .wd_second (wd_second)
  );

  assign merge_lo = (st_q == ST_FIRST)  ? mem_rdata : lo_q;
  assign merge_hi = (st_q == ST_SECOND) ? mem_rdata : '0;

  mau_read_merge u_merge (
    .lo_word (merge_lo),
    .hi_word (merge_hi),
    .off     (addr_q[OFF_W-1:0]),
    .size    (size_q),
    .sgn     (sgn_q),
    .result  (merged)
  );

  assign req_ready   = (st_q == ST_IDLE);
  assign acc_fire    = req_valid && req_ready;
  assign aligned_in  = is_aligned(req_addr[OFF_W-1:0], req_size);
  assign txn_fire    = mem_req && mem_ack;
  assign first_fire  = txn_fire && (st_q == ST_FIRST);
  assign second_fire = txn_fire && (st_q == ST_SECOND);
  assign in_second   = (st_q == ST_SECOND);
  assign base_addr   = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (acc_fire) st_d = (strict_mode && !aligned_in) ? ST_TRAP : ST_FIRST;
      ST_FIRST:  if (mem_ack) st_d = split_q ? ST_SECOND : ST_DONE;
      ST_SECOND: if (mem_ack) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      ST_TRAP:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      size_q   <= '0;
      sgn_q    <= 1'b0;
      we_q     <= 1'b0;
      strict_q <= 1'b0;
      wd_q     <= '0;
      lo_q     <= '0;
      rdata_q  <= '0;
    end else begin
      st_q <= st_d;
      if (acc_fire) begin
        addr_q   <= req_addr;
        size_q   <= req_size;
        sgn_q    <= req_signed;
        we_q     <= req_write;
        strict_q <= strict_mode;
        wd_q     <= req_wdata;
      end
      if (first_fire) lo_q <= mem_rdata;
      if ((first_fire && !split_q) || second_fire)
        rdata_q <= we_q ? '0 : merged;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = we_q;
    mem_addr  = base_addr;
    mem_be    = be_first;
    mem_wdata = wd_first;
    if (st_q == ST_FIRST) begin
      mem_req = 1'b1;
    end else if (st_q == ST_SECOND) begin
      mem_req   = 1'b1;
      mem_addr  = base_addr + WORD_STEP;
      mem_be    = be_second;
      mem_wdata = wd_second;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign resp_done  = (st_q == ST_DONE);
  assign resp_rdata = rdata_q;
  assign trap_pulse = (st_q == ST_TRAP);
  assign trap_addr  = addr_q;

  AST_ALIGNED_ONE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    first_fire && aligned_q |=> resp_done) else $error("aligned access took a second transaction"); // R2
  AST_SPLIT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    first_fire && split_q |=> busy && mem_req) else $error("split lost its second half"); // R3
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_be != '0) else $error("transaction with no lanes"); // R5
  AST_TRAP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> !mem_req && !resp_done) else $error("memory touched on trap"); // R6
  AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |=> !trap_pulse) else $error("trap longer than one cycle"); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done) else $error("done longer than one cycle"); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be)) else $error("request dropped before ack"); // R8
  AST_STRICT_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_second |-> !strict_q) else $error("strict policy split an access"); // R10

endmodule

// File: tb/misalign_access_unit_tb_top.sv
module misalign_access_unit_tb_top;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        strict_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_done;
  logic [31:0] resp_rdata;
  logic        trap_pulse;
  logic [AW-1:0] trap_addr;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  misalign_access_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_done(resp_done), .resp_rdata(resp_rdata),
    .trap_pulse(trap_pulse), .trap_addr(trap_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct {
    bit          is_trap;
    bit          is_write;
    logic [31:0] rdata;
    logic [31:0] addr;
    int          txn;
    int          lat;
    int          acc;
    bit          mis;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          fast_ack = 1'b1;
  bit          done_all = 1'b0;
  bit          ready_busy_bad = 1'b0;
  logic [31:0] lfsr = 32'h1234_5679;
  int          txn_total = 0;
  int          txn_mark = 0;

  logic [7:0]  ref_mem [256];
  logic [31:0] dev_mem [64];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: decides ack at the falling edge, applies writes there
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else begin
      logic go;
      lfsr = next_rand(lfsr);
      go = mem_req && (fast_ack || lfsr[0]);
      mem_ack <= go;
      if (go) begin
        int w;
        w = int'(mem_addr[7:2]);
        mem_rdata <= dev_mem[w];
        txn_total++;
        if (mem_we)
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) dev_mem[w][8*b +: 8] = mem_wdata[8*b +: 8];
      end
    end
  end

  // monitor: compares completions against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && req_ready) ready_busy_bad = 1'b1;
      if (resp_done || trap_pulse) begin
        int n_txn;
        n_txn = txn_total - txn_mark;
        txn_mark = txn_total;
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "completion with nothing outstanding", 32'(resp_done), 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(trap_pulse == e.is_trap && resp_done != e.is_trap, "R1",
                "trap versus done", 32'(trap_pulse), 32'(e.is_trap));
          if (e.is_trap) begin
            check(trap_addr == e.addr, "R6", "trap address", trap_addr, e.addr);
            check(n_txn == 0, "R10", "transactions on trapped access", 32'(n_txn), 32'd0);
          end else begin
            if (e.txn == 2)
              check(n_txn == 2, "R3", "split transaction count", 32'(n_txn), 32'd2);
            else if (e.mis)
              check(n_txn == 1, "R9", "in-word misaligned count", 32'(n_txn), 32'd1);
            else
              check(n_txn == 1, "R2", "aligned transaction count", 32'(n_txn), 32'd1);
            if (e.is_write)
              check(resp_rdata == 32'd0, "R7", "write result", resp_rdata, 32'd0);
            else
              check(resp_rdata == e.rdata, "R4", "read data", resp_rdata, e.rdata);
          end
          if (e.lat >= 0)
            check(cyc - e.acc == e.lat, e.is_trap ? "R6" : (e.txn == 2 ? "R3" : "R2"),
                  "latency", 32'(cyc - e.acc), 32'(e.lat));
        end
      end
    end
  end

  task automatic do_acc(input bit wr, input logic [1:0] sz, input bit sgn,
                        input logic [31:0] addr, input logic [31:0] wd);
    exp_t e;
    int   n;
    int   off;
    logic [31:0] val;
    n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off = int'(addr[1:0]);
    e.mis      = (int'(addr) % n) != 0;
    e.is_trap  = strict_mode && e.mis;
    e.is_write = wr;
    e.addr     = addr;
    e.txn      = e.is_trap ? 0 : ((off + n > 4) ? 2 : 1);
    e.rdata    = '0;
    if (!e.is_trap) begin
      if (wr) begin
        for (int k = 0; k < n; k++) ref_mem[(int'(addr) + k) % 256] = wd[8*k +: 8];
      end else begin
        val = '0;
        for (int k = 0; k < n; k++) val[8*k +: 8] = ref_mem[(int'(addr) + k) % 256];
        if (sgn && n < 4) val = 32'($signed(val << (32 - 8*n)) >>> (32 - 8*n));
        e.rdata = val;
      end
    end
    e.lat = fast_ack ? (e.is_trap ? 1 : e.txn + 1) : -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_size   = sz;
    req_signed = sgn;
    req_addr   = addr;
    req_wdata  = wd;
    e.acc = cyc;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sweep(input int base);
    logic [31:0] d;
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off++) begin
        lfsr = next_rand(lfsr);
        d = lfsr ^ 32'h8080_8080;
        do_acc(1'b1, 2'(sz), 1'b0, 32'(base + 8*(4*sz + off) + off), d);
        do_acc(1'b0, 2'(sz), 1'b0, 32'(base + 8*(4*sz + off) + off), 32'd0);
        do_acc(1'b0, 2'(sz), 1'b1, 32'(base + 8*(4*sz + off) + off), 32'd0);
        do_acc(1'b0, 2'(sz), 1'b1, 32'(base + 8*(4*sz + off) + 3), 32'd0);
      end
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((sb_q.size() != 0 || busy) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 37 + 11) ^ 8'h5a;
    for (int w = 0; w < 64; w++)
      for (int b = 0; b < 4; b++) dev_mem[w][8*b +: 8] = ref_mem[4*w + b];
    repeat (4) @(negedge clk);
    // reset state
    check(req_ready == 1'b1, "R8", "ready in reset", 32'(req_ready), 32'd1);
    check(busy == 1'b0, "R8", "busy in reset", 32'(busy), 32'd0);
    check(mem_req == 1'b0, "R8", "mem_req in reset", 32'(mem_req), 32'd0);
    check(resp_done == 1'b0 && trap_pulse == 1'b0, "R7", "pulses in reset",
          32'(resp_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready after reset", 32'(req_ready), 32'd1);

    // permissive, immediate ack
    fast_ack = 1'b1; strict_mode = 1'b0;
    sweep(0);
    drain();
    // strict, immediate ack
    strict_mode = 1'b1;
    sweep(100);
    drain();
    // random ack, both policies
    fast_ack = 1'b0; strict_mode = 1'b0;
    sweep(4);
    drain();
    strict_mode = 1'b1;
    sweep(96);
    drain();

    check(sb_q.size() == 0, "R7", "outstanding accesses", 32'(sb_q.size()), 32'd0);
    check(!ready_busy_bad, "R8", "ready while busy", 32'(ready_busy_bad), 32'd0);
    begin
      int bad;
      bad = 0;
      for (int w = 0; w < 64; w++)
        for (int b = 0; b < 4; b++)
          if (dev_mem[w][8*b +: 8] !== ref_mem[4*w + b]) bad++;
      check(bad == 0, "R5", "memory image bytes differing", 32'(bad), 32'd0);
    end
    done_all = 1'b1;
    finish_run();
  end

endmodule